// File: doc/BRIEF.md
# CPU Clock Divider with Source and Bypass Selection

This block produces the CPU clock from one of two incoming clocks, a system PLL clock and a crystal reference. A programmable divider sits between the chosen source and the output. Its ratio comes from a 2-bit select field. Codes 0, 1 and 2 give fixed ratios of 1, 2 and 3. Code 3 hands the ratio to a separate 9-bit count N and divides by 2N. A mux after the divider sends either the divided clock or the raw crystal reference to the output, so software can park the CPU on the crystal while the PLL is retuned.

Both incoming clocks are modelled as level signals. They are sampled by a faster block clock, and the divider counts rising edges of the selected source. The output is a registered level in the block-clock domain. A new ratio is adopted only when the running output period ends, so a reprogram never produces a shortened pulse. A reset clears every field, which leaves the output following the crystal.

Top module: `cpuclk_top`

## Requirements
- R1: While reset is held `cpuClk` is 0. Reset clears every field, so afterwards `cpuClk` follows the crystal, and a later write of select code 3 without a write of N divides by 1.
- R2: With the output mux bit at 1, select code 0 divides the source by 1 and code 1 divides it by 2, each with equal high and low times.
- R3: Select code 3 with N > 0 divides by 2N with a 50% duty cycle: high for N and low for N source periods.
- R4: Select code 3 with N = 0 divides by 1 and does not stop the clock.
- R5: Select code 2 divides by 3, with the output high for one source period and low for two.
- R6: Bit 7 of the second register (address 1) is the output mux. At 1 the output is the divider output; at 0 it is the crystal reference, whatever the divider settings.
- R7: Bit 0 of the second register is the divider source. At 1 the source is the PLL clock; at 0 it is the crystal.
- R8: A write that changes the ratio takes effect only at the end of the current output period, which still runs its full high and low lengths.
- R9: N is bits 28:20 of the first register (address 0). The select field is bits 3:2 of the second register. All other bits of both registers are ignored.
- R10: When the divider is selected with a ratio above 1, every output transition follows a rising edge of the source, so high and low times are whole source periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples both source clocks |
| rstN | input | 1 | Asynchronous active-low reset |
| pllClkIn | input | 1 | System PLL clock, sampled as a level |
| xtalClkIn | input | 1 | Crystal reference clock, sampled as a level |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 holds N, 1 holds select and mux bits |
| regWrData | input | 32 | Register write data |
| cpuClk | output | 1 | CPU clock output |

## Verification
The bench builds the block with its default parameters: a 9-bit N, 32-bit registers and the default field positions. It drives the PLL at a period of 8 block cycles and the crystal at 12. Those two unequal periods let the measured high and low times show which source is feeding the divider. An N of 256 sets only the top bit of the N field, so the field's full placement is exercised. Reprogramming a 16:1 ratio partway through its high phase shows that the running period completes.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

  localparam int CPUCLK_N_W     = 9;
  localparam int CPUCLK_RATIO_W = CPUCLK_N_W + 1;

  // ratio requested by the register fields, already decoded
  typedef struct packed {
    logic [CPUCLK_RATIO_W-1:0] ratio;
    logic [CPUCLK_RATIO_W-1:0] highLen;
  } divCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic srcSel;
    logic outSel;
  } ctrlStrb_t;

endpackage

// File: rtl/cpuclk_ctrl.sv
module cpuclk_ctrl
  import cpuclk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_LSB   = 20,
  parameter int SEL_LSB = 2,
  parameter int OUT_BIT = 7,
  parameter int SRC_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              periodEnd,
  output divCfg_t           reqCfg,
  output ctrlStrb_t         strb
);

  localparam int N_W     = CPUCLK_N_W;
  localparam int RATIO_W = CPUCLK_RATIO_W;
  localparam int SEL_W   = 2;

  logic [N_W-1:0]   nField;
  logic [SEL_W-1:0] selField;
  logic             outSelQ;
  logic             srcSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nField   <= '0;
      selField <= '0;
      outSelQ  <= 1'b0;
      srcSelQ  <= 1'b0;
    end else if (regWrEn) begin
      if (!regAddr) begin
        nField <= regWrData[N_LSB +: N_W];
      end else begin
        selField <= regWrData[SEL_LSB +: SEL_W];
        outSelQ  <= regWrData[OUT_BIT];
        srcSelQ  <= regWrData[SRC_BIT];
      end
    end
  end

  // ratio decode: fixed 1..3, or even 2N with N=0 folded to 1
  always_comb begin
    case (selField)
      2'd0:    reqCfg.ratio = RATIO_W'(1);
      2'd1:    reqCfg.ratio = RATIO_W'(2);
      2'd2:    reqCfg.ratio = RATIO_W'(3);
      default: reqCfg.ratio = (nField == '0) ? RATIO_W'(1) : {nField, 1'b0};
    endcase
    if (reqCfg.ratio == RATIO_W'(3) || reqCfg.ratio == RATIO_W'(1)) begin
      reqCfg.highLen = RATIO_W'(1);
    end else begin
      reqCfg.highLen = reqCfg.ratio >> 1;
    end
  end

  always_comb begin
    strb.loadCfg = periodEnd;
    strb.srcSel  = srcSelQ;
    strb.outSel  = outSelQ;
  end

endmodule

// File: rtl/cpuclk_datapath.sv
module cpuclk_datapath
  import cpuclk_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      pllClkIn,
  input  logic                      xtalClkIn,
  input  ctrlStrb_t                 strb,
  input  divCfg_t                   reqCfg,
  output logic                      periodEnd,
  output logic                      srcRise,
  output logic [CPUCLK_RATIO_W-1:0] activeRatio,
  output logic                      cpuClk
);

  localparam int RATIO_W = CPUCLK_RATIO_W;
  localparam int XTAL_IX = 0;
  localparam int PLL_IX  = 1;

  logic [NUM_SRC-1:0] srcRaw;
  logic [NUM_SRC-1:0] srcSamp;
  logic               selSrc;
  logic               srcPrev;
  logic [RATIO_W-1:0] phase;
  logic [RATIO_W-1:0] phaseNext;
  logic [RATIO_W-1:0] actHigh;
  logic               divOut;

  assign srcRaw[XTAL_IX] = xtalClkIn;
  assign srcRaw[PLL_IX]  = pllClkIn;

  // one sampling flop per incoming clock
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_samp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) srcSamp[i] <= 1'b0;
      else       srcSamp[i] <= srcRaw[i];
    end
  end

  assign selSrc    = strb.srcSel ? srcSamp[PLL_IX] : srcSamp[XTAL_IX];
  assign srcRise   = selSrc & ~srcPrev;
  assign phaseNext = phase + RATIO_W'(1);
  assign periodEnd = srcRise && (phaseNext == activeRatio);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev     <= 1'b0;
      phase       <= '0;
      activeRatio <= RATIO_W'(1);
      actHigh     <= RATIO_W'(1);
      divOut      <= 1'b0;
    end else begin
      srcPrev <= selSrc;
      if (srcRise) begin
        if (strb.loadCfg) begin
          activeRatio <= reqCfg.ratio;
          actHigh     <= reqCfg.highLen;
          phase       <= '0;
          divOut      <= 1'b1;
        end else begin
          phase  <= phaseNext;
          divOut <= (phaseNext < actHigh);
        end
      end else if (activeRatio == RATIO_W'(1)) begin
        divOut <= selSrc;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuClk <= 1'b0;
    else       cpuClk <= strb.outSel ? divOut : srcSamp[XTAL_IX];
  end

endmodule

// File: rtl/cpuclk_top.sv
module cpuclk_top
  import cpuclk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_LSB   = 20,
  parameter int SEL_LSB = 2,
  parameter int OUT_BIT = 7,
  parameter int SRC_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pllClkIn,
  input  logic              xtalClkIn,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              cpuClk
);

  divCfg_t                   reqCfg;
  ctrlStrb_t                 strb;
  logic                      periodEnd;
  logic                      srcRise;
  logic [CPUCLK_RATIO_W-1:0] activeRatio;

  cpuclk_ctrl #(
    .DATA_W (DATA_W),
    .N_LSB  (N_LSB),
    .SEL_LSB(SEL_LSB),
    .OUT_BIT(OUT_BIT),
    .SRC_BIT(SRC_BIT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .periodEnd(periodEnd),
    .reqCfg   (reqCfg),
    .strb     (strb)
  );

  cpuclk_datapath #(
    .NUM_SRC(2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pllClkIn   (pllClkIn),
    .xtalClkIn  (xtalClkIn),
    .strb       (strb),
    .reqCfg     (reqCfg),
    .periodEnd  (periodEnd),
    .srcRise    (srcRise),
    .activeRatio(activeRatio),
    .cpuClk     (cpuClk)
  );

endmodule

// File: rtl/cpuclk_checker.sv
module cpuclk_checker
  import cpuclk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OUT_BIT = 7
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      xtalClkIn,
  input logic                      regWrEn,
  input logic                      regAddr,
  input logic [DATA_W-1:0]         regWrData,
  input logic                      cpuClk,
  input ctrlStrb_t                 strb,
  input logic [CPUCLK_RATIO_W-1:0] activeRatio,
  input logic                      srcRise
);

  logic [1:0] sinceRst;
  logic       settled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  assign settled = (sinceRst == 2'd3);

  // R8: the running ratio only moves when a period-end load was signalled
  a_r8_ratio_at_period_end: assert property (@(posedge clk) disable iff (!rstN)
    (settled && activeRatio != $past(activeRatio)) |-> $past(strb.loadCfg));

  // R6: with the mux clear the output tracks the crystal two cycles later
  a_r6_bypass_tracks_xtal: assert property (@(posedge clk) disable iff (!rstN)
    (settled && !$past(strb.outSel)) |-> (cpuClk == $past(xtalClkIn, 2)));

  // R10: divided output moves only behind a source rising edge
  a_r10_edges_follow_source: assert property (@(posedge clk) disable iff (!rstN)
    (settled && $past(strb.outSel) && $past(strb.outSel, 2) &&
     ($past(activeRatio, 2) > 1) && ($past(activeRatio) > 1) &&
     (cpuClk != $past(cpuClk))) |-> $past(srcRise, 2));

  // R9: a write to address 1 lands the mux bit from its fixed position
  a_r9_mux_bit_write: assert property (@(posedge clk) disable iff (!rstN)
    (settled && regWrEn && regAddr) |=> (strb.outSel == $past(regWrData[OUT_BIT])));

endmodule

bind cpuclk_top cpuclk_checker #(
  .DATA_W (DATA_W),
  .OUT_BIT(OUT_BIT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .xtalClkIn  (xtalClkIn),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .cpuClk     (cpuClk),
  .strb       (strb),
  .activeRatio(activeRatio),
  .srcRise    (srcRise)
);

// File: tb/cpuclk_top_tb.sv
module cpuclk_top_tb;

  localparam int PLL_HALF  = 4;
  localparam int XTAL_HALF = 6;
  localparam int NVEC      = 10;

  typedef struct packed {
    logic [8:0]  n;
    logic [1:0]  sel;
    logic        outSel;
    logic        srcSel;
    logic [15:0] expHigh;
    logic [15:0] expLow;
  } vec_t;

  // PLL period 8 cycles, crystal period 12 cycles
  localparam vec_t VECS [NVEC] = '{
    '{9'd0,   2'd0, 1'b1, 1'b1, 16'd4,    16'd4},
    '{9'd0,   2'd1, 1'b1, 1'b1, 16'd8,    16'd8},
    '{9'd0,   2'd2, 1'b1, 1'b1, 16'd8,    16'd16},
    '{9'd1,   2'd3, 1'b1, 1'b1, 16'd8,    16'd8},
    '{9'd5,   2'd3, 1'b1, 1'b1, 16'd40,   16'd40},
    '{9'd0,   2'd3, 1'b1, 1'b1, 16'd4,    16'd4},
    '{9'd0,   2'd1, 1'b1, 1'b0, 16'd12,   16'd12},
    '{9'd0,   2'd2, 1'b1, 1'b0, 16'd12,   16'd24},
    '{9'd256, 2'd3, 1'b1, 1'b1, 16'd2048, 16'd2048},
    '{9'd5,   2'd3, 1'b0, 1'b1, 16'd6,    16'd6}
  };
  string vecTag [NVEC] = '{"R2", "R2", "R5", "R3", "R3", "R4", "R7", "R10", "R9", "R6"};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pllClkIn = 1'b0;
  logic        xtalClkIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic        cpuClk;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  cpuclk_top u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .pllClkIn (pllClkIn),
    .xtalClkIn(xtalClkIn),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .cpuClk   (cpuClk)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      repeat (PLL_HALF) @(negedge clk);
      pllClkIn = ~pllClkIn;
    end
  end

  initial begin
    forever begin
      repeat (XTAL_HALF) @(negedge clk);
      xtalClkIn = ~xtalClkIn;
    end
  end

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic addr, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitRise();
    logic last;
    last = cpuClk;
    forever begin
      @(negedge clk);
      if (cpuClk && !last) break;
      last = cpuClk;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    waitRise();
    hi = 0;
    while (cpuClk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!cpuClk) begin lo++; @(negedge clk); end
  endtask

  function automatic logic [31:0] ctrl1(logic [8:0] n);
    // junk outside bits 28:20 must be ignored (R9)
    return 32'h800F_FFFF | (32'(n) << 20);
  endfunction

  function automatic logic [31:0] ctrl2(logic [1:0] sel, logic o, logic s);
    // junk in bits 1,4,5,6 and above 7 must be ignored (R9)
    return 32'hFFFF_FF72 | (32'(sel) << 2) | (32'(o) << 7) | 32'(s);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    // R1: held in reset
    repeat (5) @(negedge clk);
    check("R1 cpuClk in reset", int'(cpuClk), 0);
    rstN = 1'b1;
    measure(hi, lo); measure(hi, lo);
    check("R1 xtal after reset high", hi, XTAL_HALF);
    check("R1 xtal after reset low", lo, XTAL_HALF);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b0, ctrl1(VECS[i].n));
      wr(1'b1, ctrl2(VECS[i].sel, VECS[i].outSel, VECS[i].srcSel));
      measure(hi, lo); measure(hi, lo); measure(hi, lo);
      check({vecTag[i], " high"}, hi, int'(VECS[i].expHigh));
      check({vecTag[i], " low"},  lo, int'(VECS[i].expLow));
    end

    // R8: reprogram partway through a 16:1 high phase
    wr(1'b0, ctrl1(9'd8));
    wr(1'b1, ctrl2(2'd3, 1'b1, 1'b1));
    measure(hi, lo); measure(hi, lo);
    waitRise();
    hi = 0;
    while (cpuClk) begin
      hi++;
      if (hi == 10) begin
        regWrEn = 1'b1; regAddr = 1'b1; regWrData = ctrl2(2'd0, 1'b1, 1'b1);
      end else begin
        regWrEn = 1'b0;
      end
      @(negedge clk);
    end
    regWrEn = 1'b0;
    lo = 0;
    while (!cpuClk) begin lo++; @(negedge clk); end
    check("R8 running high kept", hi, 64);
    check("R8 running low kept", lo, 64);
    measure(hi, lo); measure(hi, lo);
    check("R8 new ratio high", hi, PLL_HALF);
    check("R8 new ratio low", lo, PLL_HALF);

    // R1: reset mid-run clears N; select 3 alone then divides by 1
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cpuClk in second reset", int'(cpuClk), 0);
    rstN = 1'b1;
    measure(hi, lo); measure(hi, lo);
    check("R1 xtal after second reset", hi, XTAL_HALF);
    wr(1'b1, ctrl2(2'd3, 1'b1, 1'b1));
    measure(hi, lo); measure(hi, lo);
    check("R1 cleared N high", hi, PLL_HALF);
    check("R1 cleared N low", lo, PLL_HALF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule